// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits next to a CPU core and decides, at each instruction boundary, which interrupt the core should enter. Peripheral status flags are qualified by their enable bits and folded onto interrupt lines. One line is shared by several flag/enable pairs. Three special requests sit above all of these lines: a software trap, an illegal-opcode trap and a non-maskable request that only the X mask bit can hold off. The maskable lines are ranked by a priority table that software can rewrite.

When the core pulses `accept` and a request can be serviced, the controller latches the winning id. It also forms the vector-table address from the boot mode. It tells the core which mask bit to raise on entry. The response then stays frozen for the length of the interrupt entry sequence, and further accept strobes are ignored during that time. Stacking, the vector fetch and the core itself are outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pair is active only when its flag and its enable are both 1. A pair listed in `NOEN_MASK` (by default pair 14) is active on its flag alone. Pair p, for p at least 4, feeds maskable line p-3. An inactive pair never produces a selection.
- R2: Maskable line 0 is fed by pairs 0 to 3. It stays pending while any of those pairs is active, and it drops only when all four are inactive.
- R3: Selection order is fixed at the top: software trap (id 14), then illegal opcode (id 13), then the non-maskable request (id 12), then the maskable lines (ids 0 to 11) in table order. After reset the table holds the lines in ascending id order, so slot s holds line s.
- R4: Software-trap and illegal-opcode requests are served regardless of `ccr_i` and `ccr_x`. Each is latched by a one-cycle request pulse and is cleared when it is accepted.
- R5: While the non-maskable request is pending and `ccr_x` is 1, nothing at all is selected, including maskable lines. With `ccr_x` at 0 it is selected, and its pending state clears on acceptance.
- R6: With `ccr_i` at 1 no maskable line is selected. Accepting a maskable line does not clear it, so it is taken again while its pair stays active.
- R7: `irq_vector` = base + 2 × `irq_id`. The base is 0xFFC0 when `boot_mode` is 0 and 0xBFC0 when it is 1, sampled at the accepting edge.
- R8: On acceptance of id 12, `set_x` is 1 and `set_i` is 0. For any other id, `set_i` is 1 and `set_x` is 0.
- R9: After an accepting edge, `irq_valid`, `irq_id`, `irq_vector`, `set_i` and `set_x` hold for exactly 14 cycles and then return to 0. Accept strobes during this window are ignored, and requests arriving in the window stay pending.
- R10: After reset, `irq_valid`, `irq_id`, `irq_vector`, `set_i` and `set_x` are 0.
- R11: A write with `ord_we` = 1 stores line `ord_line` into priority slot `ord_slot`. Slot 0 is the highest priority. Writes naming a slot or line of 12 or above are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pair_flag | input | N_PAIRS (15) | Peripheral status flags |
| pair_en | input | N_PAIRS (15) | Matching enable bits |
| swi_req | input | 1 | Software-trap request pulse |
| ill_req | input | 1 | Illegal-opcode request pulse |
| xirq_req | input | 1 | Non-maskable request pulse |
| ccr_i | input | 1 | Core I mask bit |
| ccr_x | input | 1 | Core X mask bit |
| boot_mode | input | 1 | 1 selects the bootstrap vector base |
| accept | input | 1 | Instruction-boundary decision strobe |
| ord_we | input | 1 | Priority table write enable |
| ord_slot | input | LW (4) | Priority slot to write |
| ord_line | input | LW (4) | Line stored into that slot |
| irq_valid | output | 1 | An entry is in progress |
| irq_id | output | IDW (4) | Selected interrupt id |
| irq_vector | output | 16 | Vector-table address to fetch |
| set_i | output | 1 | Core must set I on entry |
| set_x | output | 1 | Core must set X on entry |

## Verification
The embedded assertions check the following on every cycle:
- the winner of the table search is really pending;
- a blocked non-maskable request produces no acceptance;
- a maskable acceptance never happens with `ccr_i` set;
- the trap pending state clears after its acceptance;
- the entry window keeps its id steady and ends after exactly the configured length;
- the vector always lands inside the correct 64-byte table.

The bench scenarios cover the rest:
- the full fixed ordering among simultaneous special requests;
- re-entry of a level-like line after a masked period;
- the shared line surviving as its pairs drop one by one;
- a rewritten priority table changing the winner;
- the bootstrap base.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam logic [15:0] VEC_BASE_NORMAL = 16'hFFC0;
  localparam logic [15:0] VEC_BASE_BOOT   = 16'hBFC0;

  // Which class of request won arbitration
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SWI,
    SRC_ILL,
    SRC_XIRQ,
    SRC_MASKABLE
  } win_src_e;

  // Vector-table address for an id, base chosen by boot mode
  function automatic logic [15:0] vec_of(input logic boot, input logic [7:0] id);
    logic [15:0] base;
    base = boot ? VEC_BASE_BOOT : VEC_BASE_NORMAL;
    return base + {7'd0, id, 1'b0};
  endfunction

endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int N_MLINES = 12,
  parameter int N_SHARED = 4,
  parameter logic [63:0] NOEN_MASK = 64'h4000,
  localparam int N_PAIRS = N_MLINES + N_SHARED - 1
) (
  input  logic [N_PAIRS-1:0]  pair_flag,
  input  logic [N_PAIRS-1:0]  pair_en,
  output logic [N_MLINES-1:0] line_pend
);

  logic [N_PAIRS-1:0] pair_act;

  // Qualify each pair; pairs without an enable bit follow their flag
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    if (NOEN_MASK[p]) begin : g_noen
      assign pair_act[p] = pair_flag[p];
    end else begin : g_en
      assign pair_act[p] = pair_flag[p] & pair_en[p];
    end
  end

  // Line 0 merges the shared group; other lines map one pair each
  assign line_pend[0] = |pair_act[N_SHARED-1:0];
  for (genvar k = 1; k < N_MLINES; k++) begin : g_line
    assign line_pend[k] = pair_act[k + N_SHARED - 1];
  end

endmodule

// File: rtl/irq_order_table.sv
module irq_order_table #(
  parameter int N_MLINES = 12,
  localparam int LW = (N_MLINES > 1) ? $clog2(N_MLINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [LW-1:0]       wr_slot,
  input  logic [LW-1:0]       wr_line,
  input  logic [N_MLINES-1:0] line_pend,
  output logic                hit,
  output logic [LW-1:0]       hit_line
);

  logic [LW-1:0] ord_q [N_MLINES];
  logic          wr_ok;

  assign wr_ok = wr_en && (int'(wr_slot) < N_MLINES) && (int'(wr_line) < N_MLINES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_MLINES; s++) ord_q[s] <= LW'(s);
    end else if (wr_ok) begin
      ord_q[wr_slot] <= wr_line;
    end
  end

  // Lowest slot whose line is pending wins
  always_comb begin
    hit      = 1'b0;
    hit_line = '0;
    for (int s = N_MLINES - 1; s >= 0; s--) begin
      if (line_pend[ord_q[s]]) begin
        hit      = 1'b1;
        hit_line = ord_q[s];
      end
    end
  end

  // R3: a reported winner must really be pending
  assert_hit_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> line_pend[hit_line]);

  // R3: no pending line may be missed
  assert_no_missed_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_pend) |-> hit);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N_MLINES = 12,
  localparam int LW  = (N_MLINES > 1) ? $clog2(N_MLINES) : 1,
  localparam int IDW = $clog2(N_MLINES + 3)
) (
  input  logic           swi_p,
  input  logic           ill_p,
  input  logic           xirq_p,
  input  logic           ccr_i,
  input  logic           ccr_x,
  input  logic           mask_hit,
  input  logic [LW-1:0]  mask_line,
  output logic           win_valid,
  output logic [IDW-1:0] win_id,
  output win_src_e       win_src,
  output logic           xirq_stall
);

  localparam logic [IDW-1:0] XIRQ_ID = IDW'(N_MLINES);
  localparam logic [IDW-1:0] ILL_ID  = IDW'(N_MLINES + 1);
  localparam logic [IDW-1:0] SWI_ID  = IDW'(N_MLINES + 2);

  // Non-maskable request held by X freezes everything below it
  assign xirq_stall = xirq_p && ccr_x;

  always_comb begin
    win_src = SRC_NONE;
    win_id  = '0;
    if (swi_p) begin
      win_src = SRC_SWI;
      win_id  = SWI_ID;
    end else if (ill_p) begin
      win_src = SRC_ILL;
      win_id  = ILL_ID;
    end else if (xirq_p) begin
      if (!ccr_x) begin
        win_src = SRC_XIRQ;
        win_id  = XIRQ_ID;
      end
    end else if (!ccr_i && mask_hit) begin
      win_src = SRC_MASKABLE;
      win_id  = IDW'(mask_line);
    end
  end

  assign win_valid = (win_src != SRC_NONE);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_prio_pkg::*;
#(
  parameter int IDW          = 4,
  parameter int ENTRY_CYCLES = 14,
  localparam int CW = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           win_valid,
  input  logic [IDW-1:0] win_id,
  input  logic           win_is_x,
  input  logic           boot_mode,
  output logic           take,
  output logic           sel_valid,
  output logic [IDW-1:0] sel_id,
  output logic [15:0]    sel_vec,
  output logic           sel_set_i,
  output logic           sel_set_x
);

  logic [CW-1:0] cnt_q;
  logic          window_end;

  assign take       = accept && !sel_valid && win_valid;
  assign window_end = sel_valid && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_id    <= '0;
      sel_vec   <= '0;
      sel_set_i <= 1'b0;
      sel_set_x <= 1'b0;
      cnt_q     <= '0;
    end else if (take) begin
      sel_valid <= 1'b1;
      sel_id    <= win_id;
      sel_vec   <= vec_of(boot_mode, 8'(win_id));
      sel_set_i <= !win_is_x;
      sel_set_x <= win_is_x;
      cnt_q     <= CW'(ENTRY_CYCLES - 1);
    end else if (window_end) begin
      sel_valid <= 1'b0;
      sel_id    <= '0;
      sel_vec   <= '0;
      sel_set_i <= 1'b0;
      sel_set_x <= 1'b0;
    end else if (sel_valid) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9: response is frozen inside the entry window
  assert_id_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !window_end) |=> (sel_valid && $stable(sel_id) && $stable(sel_vec)));

  // R9: the window closes once the counter runs out
  assert_window_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> !sel_valid);

  // R7: vector always lies inside one of the two 64-byte tables
  assert_vec_in_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_vec[0] == 1'b0) &&
                  ((sel_vec[15:6] == VEC_BASE_NORMAL[15:6]) || (sel_vec[15:6] == VEC_BASE_BOOT[15:6])));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_MLINES     = 12,
  parameter int N_SHARED     = 4,
  parameter int ENTRY_CYCLES = 14,
  parameter logic [63:0] NOEN_MASK = 64'h4000,
  localparam int N_PAIRS = N_MLINES + N_SHARED - 1,
  localparam int LW      = (N_MLINES > 1) ? $clog2(N_MLINES) : 1,
  localparam int IDW     = $clog2(N_MLINES + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PAIRS-1:0] pair_flag,
  input  logic [N_PAIRS-1:0] pair_en,
  input  logic               swi_req,
  input  logic               ill_req,
  input  logic               xirq_req,
  input  logic               ccr_i,
  input  logic               ccr_x,
  input  logic               boot_mode,
  input  logic               accept,
  input  logic               ord_we,
  input  logic [LW-1:0]      ord_slot,
  input  logic [LW-1:0]      ord_line,
  output logic               irq_valid,
  output logic [IDW-1:0]     irq_id,
  output logic [15:0]        irq_vector,
  output logic               set_i,
  output logic               set_x
);

  localparam logic [IDW-1:0] XIRQ_ID = IDW'(N_MLINES);
  localparam logic [IDW-1:0] SWI_ID  = IDW'(N_MLINES + 2);

  // Named internal events for the assertions
  logic [N_MLINES-1:0] line_pend;
  logic                mask_hit;
  logic [LW-1:0]       mask_line;
  logic                swi_p, ill_p, xirq_p;
  logic                win_valid;
  logic [IDW-1:0]      win_id;
  win_src_e            win_src;
  logic                xirq_stall;
  logic                take;
  logic                take_swi, take_ill, take_xirq, take_mask;

  irq_pend_merge #(
    .N_MLINES (N_MLINES),
    .N_SHARED (N_SHARED),
    .NOEN_MASK(NOEN_MASK)
  ) u_merge (
    .pair_flag(pair_flag),
    .pair_en  (pair_en),
    .line_pend(line_pend)
  );

  irq_order_table #(.N_MLINES(N_MLINES)) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ord_we),
    .wr_slot  (ord_slot),
    .wr_line  (ord_line),
    .line_pend(line_pend),
    .hit      (mask_hit),
    .hit_line (mask_line)
  );

  irq_arbiter #(.N_MLINES(N_MLINES)) u_arb (
    .swi_p     (swi_p),
    .ill_p     (ill_p),
    .xirq_p    (xirq_p),
    .ccr_i     (ccr_i),
    .ccr_x     (ccr_x),
    .mask_hit  (mask_hit),
    .mask_line (mask_line),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_src   (win_src),
    .xirq_stall(xirq_stall)
  );

  irq_entry_seq #(
    .IDW         (IDW),
    .ENTRY_CYCLES(ENTRY_CYCLES)
  ) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .win_valid(win_valid),
    .win_id   (win_id),
    .win_is_x (win_src == SRC_XIRQ),
    .boot_mode(boot_mode),
    .take     (take),
    .sel_valid(irq_valid),
    .sel_id   (irq_id),
    .sel_vec  (irq_vector),
    .sel_set_i(set_i),
    .sel_set_x(set_x)
  );

  assign take_swi  = take && (win_src == SRC_SWI);
  assign take_ill  = take && (win_src == SRC_ILL);
  assign take_xirq = take && (win_src == SRC_XIRQ);
  assign take_mask = take && (win_src == SRC_MASKABLE);

  // One-shot pending state: a new request wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_p  <= 1'b0;
      ill_p  <= 1'b0;
      xirq_p <= 1'b0;
    end else begin
      swi_p  <= swi_req  | (swi_p  & ~take_swi);
      ill_p  <= ill_req  | (ill_p  & ~take_ill);
      xirq_p <= xirq_req | (xirq_p & ~take_xirq);
    end
  end

  // R4: accepted software trap leaves no pending state behind
  assert_swi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_swi && !swi_req) |=> !swi_p);

  // R4: software trap wins whatever the mask bits say
  assert_swi_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !irq_valid && swi_p) |=> (irq_valid && irq_id == SWI_ID));

  // R5: blocked non-maskable request stalls every lower source
  assert_xirq_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xirq_stall && !swi_p && !ill_p) |-> !take);

  // R6: a maskable line is never taken with I set
  assert_i_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_mask |-> !ccr_i);

  // R8: exactly one mask-bit request, X only for the non-maskable id
  assert_mask_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((set_x == (irq_id == XIRQ_ID)) && (set_i != set_x)));

  // R10: idle outputs are quiet
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (!set_i && !set_x && irq_vector == 16'h0));

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  localparam int NP = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pair_flag = '0;
  logic [NP-1:0] pair_en = '0;
  logic          swi_req = 1'b0, ill_req = 1'b0, xirq_req = 1'b0;
  logic          ccr_i = 1'b0, ccr_x = 1'b0, boot_mode = 1'b0, accept = 1'b0;
  logic          ord_we = 1'b0;
  logic [3:0]    ord_slot = '0, ord_line = '0;
  logic          irq_valid;
  logic [3:0]    irq_id;
  logic [15:0]   irq_vector;
  logic          set_i, set_x;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pair_flag(pair_flag), .pair_en(pair_en),
    .swi_req(swi_req), .ill_req(ill_req), .xirq_req(xirq_req),
    .ccr_i(ccr_i), .ccr_x(ccr_x), .boot_mode(boot_mode), .accept(accept),
    .ord_we(ord_we), .ord_slot(ord_slot), .ord_line(ord_line),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_vector(irq_vector),
    .set_i(set_i), .set_x(set_x)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          at;
    logic        valid;
    logic [3:0]  id;
    logic [15:0] vec;
    logic        si;
    logic        sx;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected vector address, written from the requirement text
  function automatic logic [15:0] ref_vec(input logic boot, input int id);
    int base;
    base = boot ? 49088 : 65472;
    return 16'(base + id * 2);
  endfunction

  function automatic exp_t mk(input int at, input logic v, input int id, input logic boot, input string tag);
    exp_t e;
    e.at    = at;
    e.valid = v;
    e.id    = v ? 4'(id) : 4'd0;
    e.vec   = v ? ref_vec(boot, id) : 16'h0;
    e.si    = v && (id != 12);
    e.sx    = v && (id == 12);
    e.tag   = tag;
    return e;
  endfunction

  // Monitor: compare every item due in this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (e.at != cyc || irq_valid !== e.valid || irq_id !== e.id ||
          irq_vector !== e.vec || set_i !== e.si || set_x !== e.sx) begin
        n_fail++;
        $display("FAIL %s: got valid=%0b id=%0d vec=%h i=%0b x=%0b, expected valid=%0b id=%0d vec=%h i=%0b x=%0b",
                 e.tag, irq_valid, irq_id, irq_vector, set_i, set_x,
                 e.valid, e.id, e.vec, e.si, e.sx);
      end
    end
  end

  // Driver: strobe accept and queue the expected response
  task automatic do_accept(input logic v, input int id, input string tag, input bit probe_swi = 1'b0);
    accept = 1'b1;
    exp_q.push_back(mk(cyc + 1, v, id, boot_mode, tag));
    @(negedge clk);
    accept = 1'b0;
    if (v) begin
      for (int i = 0; i < 14; i++) begin
        if (probe_swi && i == 2) swi_req = 1'b1;
        if (probe_swi && i == 3) swi_req = 1'b0;
        if (i == 4) begin
          // R9: accept inside the window changes nothing
          accept = 1'b1;
          exp_q.push_back(mk(cyc + 1, 1'b1, id, boot_mode, {"R9 hold ", tag}));
        end
        if (i == 5) accept = 1'b0;
        if (i == 13) exp_q.push_back(mk(cyc + 1, 1'b0, 0, 1'b0, {"R9 window end ", tag}));
        @(negedge clk);
      end
    end
  endtask

  task automatic pulse(input int which);
    if (which == 0) swi_req = 1'b1;
    if (which == 1) ill_req = 1'b1;
    if (which == 2) xirq_req = 1'b1;
    @(negedge clk);
    swi_req = 1'b0; ill_req = 1'b0; xirq_req = 1'b0;
  endtask

  task automatic wr_order(input int slot, input int line);
    ord_we = 1'b1; ord_slot = 4'(slot); ord_line = 4'(line);
    @(negedge clk);
    ord_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(mk(cyc, 1'b0, 0, 1'b0, "R10 reset state"));
    @(negedge clk);

    // R1: flag without enable is not pending
    pair_flag[5] = 1'b1;
    do_accept(1'b0, 0, "R1 flag only");
    @(negedge clk);
    // R1 R7 R8 R9: qualified pair, window probe with a trap arriving mid-window
    pair_en[5] = 1'b1;
    do_accept(1'b1, 2, "R1 R7 R8 pair5 line2", 1'b1);
    // R4 R3: trap served with both masks set
    ccr_i = 1'b1; ccr_x = 1'b1;
    do_accept(1'b1, 14, "R4 R3 swi under masks");
    // R4 R6: trap cleared, maskable held off by I
    do_accept(1'b0, 0, "R4 R6 cleared and masked");
    @(negedge clk);
    // R6: level-like line taken again
    ccr_i = 1'b0; ccr_x = 1'b0;
    do_accept(1'b1, 2, "R6 retake");

    // R2: shared line
    pair_flag = '0; pair_en = '0;
    pair_flag[1] = 1'b1; pair_en[1] = 1'b1;
    pair_flag[2] = 1'b1; pair_en[2] = 1'b1;
    do_accept(1'b1, 0, "R2 two pairs");
    pair_flag[1] = 1'b0;
    do_accept(1'b1, 0, "R2 one pair left");
    pair_flag[2] = 1'b0;
    do_accept(1'b0, 0, "R2 all dropped");
    @(negedge clk);

    // R3 R11: identity order, then swapped
    pair_flag[0] = 1'b1; pair_en[0] = 1'b1;
    pair_flag[5] = 1'b1; pair_en[5] = 1'b1;
    do_accept(1'b1, 0, "R3 identity order");
    wr_order(0, 2);
    wr_order(2, 0);
    wr_order(13, 1);  // out of range slot, dropped
    do_accept(1'b1, 2, "R11 reordered");

    // R1: pair without enable bit
    pair_flag = '0; pair_en = '0;
    pair_flag[14] = 1'b1;
    do_accept(1'b1, 11, "R1 no-enable pair");

    // R5: blocked non-maskable stalls maskable line
    pulse(2);
    ccr_x = 1'b1;
    do_accept(1'b0, 0, "R5 stall");
    @(negedge clk);
    ccr_x = 1'b0;
    do_accept(1'b1, 12, "R5 R8 xirq taken");
    do_accept(1'b1, 11, "R5 xirq cleared");

    // R3 R4: illegal over non-maskable, with I set
    ccr_i = 1'b1;
    pulse(1);
    pulse(2);
    do_accept(1'b1, 13, "R3 R4 ill first");
    do_accept(1'b1, 12, "R3 xirq next");
    do_accept(1'b0, 0, "R6 masked tail");
    @(negedge clk);

    // R7: bootstrap base
    ccr_i = 1'b0; boot_mode = 1'b1;
    do_accept(1'b1, 11, "R7 boot base");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: got %0d unchecked items, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule